// File: doc/BRIEF.md
# Extension Channel Busy Estimator

This block estimates how busy a secondary (extension) radio channel has been since the previous measurement. The result is a whole percentage from 0 to 100. Three free-running 32-bit counters feed it: total cycles, cycles the primary (control) channel was busy, and cycles the extension channel was busy.

On each accepted measurement request, the block does the following:
- It compares the live counter values with a stored snapshot from the previous request and forms unsigned deltas.
- It derives the number of cycles in which the control channel was clear.
- It divides the extension busy delta, scaled by 100, by that clear time. A restoring shift-subtract divider does this, one quotient bit per cycle.
- It stores the live values as the new snapshot.

The ratio is taken against control-channel clear time, not total time. The extension channel's busy indication is only meaningful while the control channel is clear.

Three guard rules replace the division in special cases:
- A first measurement or a wrapped cycle counter reports 0.
- No clear time reports 100.
- Any larger quotient is clamped to 100.

A one-cycle done pulse marks each result. The percentage output holds its value until the next result.

Top module: `ext_busy_estimator`

## Requirements
- R1: After reset, done_o is low, busy_pct_o is 0 and all three stored snapshot values are zero.
- R2: A request whose stored previous cycle count is zero reports 0, with done_o high in the cycle following the accepting clock edge.
- R3: A request whose stored previous cycle count is greater than the live cycle count reports 0, with done_o high in the cycle following the accepting edge.
- R4: Control-clear time is the cycle delta minus the control busy delta when the cycle delta is strictly larger, and zero otherwise.
- R5: When control-clear time is zero (and R2/R3 do not apply), the result is 100, with done_o high in the cycle following the accepting edge.
- R6: Otherwise the result is floor(extension busy delta × 100 / control-clear time). With the default 40 dividend bits, done_o is high in the cycle after the 40th division step, which is the 41st cycle after the accepting edge.
- R7: A quotient above 100 is reported as exactly 100; busy_pct_o never exceeds 100.
- R8: Every accepted request, including the R2 and R3 cases, replaces the stored snapshot with the live counter values.
- R9: All deltas are unsigned 32-bit differences (live minus stored), so a counter that rolled over once still yields its true delta.
- R10: A request is accepted only while the block is idle; a request during a computation or during the done cycle leaves the snapshot and the pending result untouched.
- R11: done_o is high for exactly one cycle per accepted request, and busy_pct_o holds its value between done pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Measurement request, sampled on the rising edge |
| cyc_cnt_i | input | 32 | Live total cycle counter |
| ctl_busy_i | input | 32 | Live control-channel busy counter |
| ext_busy_i | input | 32 | Live extension-channel busy counter |
| busy_pct_o | output | 8 | Latest busy percentage, 0 to 100 |
| done_o | output | 1 | One-cycle pulse when busy_pct_o is updated |

## Verification
The embedded properties check the following on every cycle:
- the done pulse is a single cycle wide;
- the percentage never exceeds 100;
- the wrap and zero-clear shortcuts produce 0 or 100 one cycle after acceptance;
- the divider takes exactly its step count and is never started while busy or with a zero divisor;
- the snapshot changes only on an accepted request, and then to the live values.

The arithmetic itself can only be shown by the bench's scenarios, which compare against a reference model. These scenarios cover:
- floor rounding of the quotient;
- the strict comparison that defines clear time;
- 32-bit modular deltas across a counter rollover;
- a snapshot refreshed after a wrap;
- a request injected mid-division that must not disturb the next measurement.

// File: rtl/ebe_pkg.sv
package ebe_pkg;

  localparam int unsigned EBE_CNT_W    = 32;
  localparam int unsigned EBE_DVD_W    = 40;
  localparam int unsigned EBE_PCT_W    = 8;
  localparam int unsigned EBE_PCT_FULL = 100;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_FIN  = 2'd2
  } ebe_state_e;

endpackage

// File: rtl/ebe_snapshot.sv
module ebe_snapshot #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_i,
  input  logic [CNT_W-1:0] cyc_i,
  input  logic [CNT_W-1:0] ctl_i,
  input  logic [CNT_W-1:0] ext_i,
  output logic             wrap_o,
  output logic [CNT_W-1:0] cyc_dlt_o,
  output logic [CNT_W-1:0] ctl_dlt_o,
  output logic [CNT_W-1:0] ext_dlt_o
);

  localparam int unsigned NCH = 3;

  logic [NCH-1:0][CNT_W-1:0] live;
  logic [NCH-1:0][CNT_W-1:0] prev_q;
  logic [NCH-1:0][CNT_W-1:0] prev_d;
  logic [NCH-1:0][CNT_W-1:0] dlt;

  assign live[0] = cyc_i;
  assign live[1] = ctl_i;
  assign live[2] = ext_i;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_comb begin
      prev_d[g] = prev_q[g];
      if (capture_i) prev_d[g] = live[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= '0;
      else        prev_q[g] <= prev_d[g];
    end

    // modular difference: one rollover still gives the true delta
    assign dlt[g] = live[g] - prev_q[g];
  end

  assign wrap_o    = (prev_q[0] == '0) || (prev_q[0] > cyc_i);
  assign cyc_dlt_o = dlt[0];
  assign ctl_dlt_o = dlt[1];
  assign ext_dlt_o = dlt[2];

  assert_snap_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i |=> (prev_q[0] == $past(cyc_i)) && (prev_q[1] == $past(ctl_i))
                  && (prev_q[2] == $past(ext_i)));

  assert_snap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_i |=> $stable(prev_q));

endmodule

// File: rtl/ebe_divider.sv
module ebe_divider #(
  parameter int unsigned DVD_W = 40,
  parameter int unsigned DSR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DSR_W-1:0] divisor_i,
  output logic             busy_o,
  output logic             last_o,
  output logic [DVD_W-1:0] quo_nxt_o
);

  localparam int unsigned STEP_W = $clog2(DVD_W + 1);

  logic [DVD_W-1:0]  dq_q, dq_d, dq_step;
  logic [DSR_W-1:0]  rem_q, rem_d;
  logic [DSR_W-1:0]  dsr_q, dsr_d;
  logic [STEP_W-1:0] cnt_q, cnt_d;
  logic              busy_q, busy_d;
  logic [DSR_W:0]    rem_sh, rem_sub;
  logic              fits;

  // one restoring step: shift in the next dividend bit, try to subtract
  always_comb begin
    rem_sh  = {rem_q, dq_q[DVD_W-1]};
    rem_sub = rem_sh - {1'b0, dsr_q};
    fits    = (rem_sh >= {1'b0, dsr_q});
    dq_step = {dq_q[DVD_W-2:0], fits};
  end

  assign last_o    = busy_q && (cnt_q == STEP_W'(DVD_W - 1));
  assign busy_o    = busy_q;
  assign quo_nxt_o = dq_step;

  always_comb begin
    dq_d   = dq_q;
    rem_d  = rem_q;
    dsr_d  = dsr_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start_i) begin
      dq_d   = dividend_i;
      rem_d  = '0;
      dsr_d  = divisor_i;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      dq_d  = dq_step;
      rem_d = fits ? rem_sub[DSR_W-1:0] : rem_sh[DSR_W-1:0];
      cnt_d = cnt_q + STEP_W'(1);
      if (last_o) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_q   <= '0;
      rem_q  <= '0;
      dsr_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      dq_q   <= dq_d;
      rem_q  <= rem_d;
      dsr_q  <= dsr_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assert_start_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_q);

  assert_nonzero_divisor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (divisor_i != '0));

  assert_keep_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_o) |=> busy_q);

endmodule

// File: rtl/ext_busy_estimator.sv
module ext_busy_estimator
  import ebe_pkg::*;
#(
  parameter int unsigned CNT_W    = EBE_CNT_W,
  parameter int unsigned DVD_W    = EBE_DVD_W,
  parameter int unsigned PCT_W    = EBE_PCT_W,
  parameter int unsigned PCT_FULL = EBE_PCT_FULL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [CNT_W-1:0] cyc_cnt_i,
  input  logic [CNT_W-1:0] ctl_busy_i,
  input  logic [CNT_W-1:0] ext_busy_i,
  output logic [PCT_W-1:0] busy_pct_o,
  output logic             done_o
);

  localparam int unsigned LAT_W = $clog2(DVD_W + 2);

  ebe_state_e       state_q, state_d;
  logic [PCT_W-1:0] pct_q, pct_d;
  logic             accept, wrap, clear_zero, div_start;
  logic             div_busy, div_last;
  logic [CNT_W-1:0] cyc_dlt, ctl_dlt, ext_dlt, clear_dlt;
  logic [DVD_W-1:0] dividend, quo_nxt;
  logic [PCT_W-1:0] quo_clamped;

  assign accept = req_i && (state_q == ST_IDLE);

  ebe_snapshot #(.CNT_W(CNT_W)) u_snap (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (accept),
    .cyc_i     (cyc_cnt_i),
    .ctl_i     (ctl_busy_i),
    .ext_i     (ext_busy_i),
    .wrap_o    (wrap),
    .cyc_dlt_o (cyc_dlt),
    .ctl_dlt_o (ctl_dlt),
    .ext_dlt_o (ext_dlt)
  );

  // clear time only counts when total time strictly exceeds control busy time
  assign clear_dlt  = (cyc_dlt > ctl_dlt) ? (cyc_dlt - ctl_dlt) : '0;
  assign clear_zero = (clear_dlt == '0);
  assign dividend   = DVD_W'(ext_dlt) * DVD_W'(PCT_FULL);
  assign div_start  = accept && !wrap && !clear_zero;

  ebe_divider #(.DVD_W(DVD_W), .DSR_W(CNT_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (div_start),
    .dividend_i (dividend),
    .divisor_i  (clear_dlt),
    .busy_o     (div_busy),
    .last_o     (div_last),
    .quo_nxt_o  (quo_nxt)
  );

  assign quo_clamped = (quo_nxt > DVD_W'(PCT_FULL)) ? PCT_W'(PCT_FULL)
                                                    : quo_nxt[PCT_W-1:0];

  always_comb begin
    state_d = state_q;
    pct_d   = pct_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (wrap) begin
            pct_d   = '0;
            state_d = ST_FIN;
          end else if (clear_zero) begin
            pct_d   = PCT_W'(PCT_FULL);
            state_d = ST_FIN;
          end else begin
            state_d = ST_DIV;
          end
        end
      end
      ST_DIV: begin
        if (div_last) begin
          pct_d   = quo_clamped;
          state_d = ST_FIN;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pct_q   <= '0;
    end else begin
      state_q <= state_d;
      pct_q   <= pct_d;
    end
  end

  assign busy_pct_o = pct_q;
  assign done_o     = (state_q == ST_FIN);

  // step counter used only by the latency property
  logic [LAT_W-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 lat_q <= '0;
    else if (accept)            lat_q <= '0;
    else if (state_q == ST_DIV) lat_q <= lat_q + LAT_W'(1);
  end

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_pct_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_pct_o <= PCT_W'(PCT_FULL));

  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wrap) |=> (done_o && (busy_pct_o == '0)));

  assert_noclear_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !wrap && clear_zero) |=> (done_o && (busy_pct_o == PCT_W'(PCT_FULL))));

  assert_div_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && ($past(state_q) == ST_DIV)) |-> (lat_q == LAT_W'(DVD_W)));

  assert_div_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !div_busy);

  assert_pct_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |=> (done_o || $stable(busy_pct_o)));

endmodule

// File: tb/ext_busy_estimator_tb.sv
`timescale 1ns/1ps
module ext_busy_estimator_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req;
  logic [31:0] cyc, ctl, ext;
  logic [7:0]  pct;
  logic        done;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] m_cyc = '0, m_ctl = '0, m_ext = '0;

  always #2.5 clk = ~clk;

  ext_busy_estimator u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req),
    .cyc_cnt_i  (cyc),
    .ctl_busy_i (ctl),
    .ext_busy_i (ext),
    .busy_pct_o (pct),
    .done_o     (done)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference: expected percentage and latency, then snapshot update
  task automatic model(input logic [31:0] c, t, e, output int ep, output int el);
    logic [31:0] cd, td, ed, clr;
    longint q;
    if (m_cyc == 0 || m_cyc > c) begin
      ep = 0; el = 1;
    end else begin
      cd = c - m_cyc; td = t - m_ctl; ed = e - m_ext;
      clr = (cd > td) ? cd - td : 32'd0;
      if (clr == 0) begin
        ep = 100; el = 1;
      end else begin
        q  = (longint'(ed) * 100) / longint'(clr);
        ep = (q > 100) ? 100 : int'(q);
        el = 41;
      end
    end
    m_cyc = c; m_ctl = t; m_ext = e;
  endtask

  task automatic do_req(input logic [31:0] c, t, e, input int inject,
                        input string tag, output int lat);
    lat = 0;
    @(negedge clk);
    cyc = c; ctl = t; ext = e; req = 1'b1;
    for (int i = 1; i <= 100; i++) begin
      @(negedge clk);
      req = 1'b0;
      if (i == inject) begin
        req = 1'b1;
        cyc = 32'd99999999; ctl = 32'd7; ext = 32'd5;
      end
      if (done) begin
        lat = i;
        break;
      end
      if (i > 1 && done) chk({tag, " R11 early done"}, 1, 0);
    end
    req = 1'b0;
  endtask

  task automatic run_case(input logic [31:0] c, t, e, input string tag, input int inject);
    int ep, el, lat;
    model(c, t, e, ep, el);
    do_req(c, t, e, inject, tag, lat);
    chk({tag, " pct"}, longint'(pct), ep);
    chk({tag, " latency"}, lat, el);
  endtask

  task automatic t_reset;
    chk("R1 done after reset", done, 0);
    chk("R1 pct after reset", pct, 0);
  endtask

  task automatic t_first;
    run_case(32'd1000, 32'd100, 32'd50, "R2 first request", 0);
    run_case(32'd2000, 32'd600, 32'd200, "R6 R4 ratio 30", 0);
  endtask

  task automatic t_floor;
    run_case(32'd3000, 32'd1100, 32'd333, "R6 floor 26", 0);
    run_case(32'd3500, 32'd1350, 32'd583, "R6 exact 100", 0);
  endtask

  task automatic t_noclear;
    run_case(32'd4000, 32'd1850, 32'd600, "R4 R5 equal deltas", 0);
  endtask

  task automatic t_clamp;
    run_case(32'd5000, 32'd1950, 32'd1600, "R7 clamp 111", 0);
    run_case(32'd6000, 32'd2949, 32'h8000_1600, "R7 clamp huge", 0);
  endtask

  task automatic t_wrap;
    run_case(32'd100, 32'd3000, 32'd1500, "R3 wrap", 0);
    run_case(32'd1100, 32'd3100, 32'd1700, "R8 after wrap", 0);
  endtask

  task automatic t_modulo;
    run_case(32'd2100, 32'hFFFF_FFF0, 32'd1800, "R9 setup", 0);
    run_case(32'd3100, 32'h0000_0010, 32'd1850, "R9 ctl rollover", 0);
  endtask

  task automatic t_ignore;
    logic [7:0] held;
    run_case(32'd4100, 32'h0000_0204, 32'd1950, "R10 inject", 5);
    held = pct;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk("R11 no extra done", done, 0);
      chk("R11 pct held", pct, held);
    end
    run_case(32'd5100, 32'h0000_03F8, 32'd2200, "R10 snapshot kept", 0);
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    chk("watchdog", 1, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; cyc = '0; ctl = '0; ext = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first();
    t_floor();
    t_noclear();
    t_clamp();
    t_wrap();
    t_modulo();
    t_ignore();
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule